// File: doc/BRIEF.md
# Receive Queue Index Manager

This block tracks where received messages go in a circular queue that lives in an external message RAM. It keeps the write (put) index, the read (get) index, the fill level and the full status, and it computes the RAM word address at which the next received element is to be stored. A write strobe records that an element has been stored at that address. A read-acknowledge retires the element at the get index.

The queue depth, a watermark level, the behaviour on a full queue and the base word address all come from configuration inputs. The depth code clamps to 64, and a depth of zero turns the queue off. A watermark code outside 1..64 turns the watermark interrupt off. When the queue is full, a new message is either dropped and reported as lost, or it replaces the oldest stored element. Three sticky interrupt flags report reaching the watermark, becoming full and losing a message. A single clear input drops all three flags.

Top module: `rxq_index_mgr`

## Requirements
- R1: With `cfg_size` equal to 0 the queue does not exist: `wr_stb` and `rd_ack` change no index, level or flag.
- R2: A `cfg_size` above 64 behaves exactly as 64. A value from 1 to 64 is the element count.
- R3: `put_idx` and `get_idx` count from 0 to the element count minus 1 and then return to 0.
- R4: `irq_wm` is set in the cycle after the fill level changes to a value equal to `cfg_wmark`, when `cfg_wmark` is 1 to 64. A value of 0 or above 64 never sets it.
- R5: When `cfg_ovw` is 0 and the queue is full, a write without an accepted read-acknowledge is discarded and sets `irq_lost`. Indices and level do not change.
- R6: When `cfg_ovw` is 1 and the queue is full, a write without a read-acknowledge replaces the oldest element. Both indices advance, the level stays the same and `irq_lost` is not set.
- R7: `fill_lvl` is the number of stored elements, from 0 to 64. `full` is 1 exactly when `fill_lvl` equals the element count and the count is nonzero. `irq_full` is set in the cycle after the level changes to the element count.
- R8: `wr_addr` equals `cfg_start + put_idx * ELEM_WORDS`, truncated to `ADDR_W` bits.
- R9: A read-acknowledge on an empty queue has no effect. An accepted write together with an accepted acknowledge in one cycle advances both indices and leaves the level unchanged. On a full queue this pair is accepted in either mode.
- R10: Each interrupt flag stays at 1 until a cycle with `irq_clr` high. A new event in that same cycle keeps the flag set.
- R11: While `rst_n` is low, all indices, the level and the flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_size | input | 7 | Element count code (0 = off, above 64 = 64) |
| cfg_wmark | input | 7 | Watermark level (0 or above 64 = off) |
| cfg_ovw | input | 1 | 1 = overwrite oldest when full, 0 = drop new |
| cfg_start | input | 14 | Base word address of the queue |
| wr_stb | input | 1 | A received element was stored at `wr_addr` |
| rd_ack | input | 1 | The element at `get_idx` has been consumed |
| irq_clr | input | 1 | Clears all three interrupt flags |
| wr_addr | output | 16 | Word address for the next element |
| put_idx | output | 6 | Next write index |
| get_idx | output | 6 | Oldest element index |
| fill_lvl | output | 7 | Stored element count |
| full | output | 1 | Queue holds the configured element count |
| irq_wm | output | 1 | Sticky watermark interrupt |
| irq_full | output | 1 | Sticky full interrupt |
| irq_lost | output | 1 | Sticky message-lost interrupt |

## Verification
The assertions assume that the configuration inputs stay constant between resets. The index range and full-level properties compare the outputs with the current depth code, so they only hold if the depth has not changed under a partly filled queue. The bench therefore changes `cfg_size`, `cfg_wmark`, `cfg_ovw` and `cfg_start` only while reset is held. Random strobes, acknowledges and clears then run against each fixed configuration. The depth codes include 0, 1, values at 64 and values above 64.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int MAX_ELEMS = 64;
  localparam int IDX_W     = 6;
  localparam int LVL_W     = 7;
  localparam int CODE_W    = 7;

  // Clamp a depth code to the supported element count.
  function automatic logic [LVL_W-1:0] clamp_size(input logic [CODE_W-1:0] code);
    if (int'(code) > MAX_ELEMS) return LVL_W'(MAX_ELEMS);
    return LVL_W'(code);
  endfunction

  // Watermark is usable only for 1..MAX_ELEMS.
  function automatic logic wmark_on(input logic [CODE_W-1:0] code);
    return (code != '0) && (int'(code) <= MAX_ELEMS);
  endfunction

  // Step an index around a ring of `count` slots.
  function automatic logic [IDX_W-1:0] ring_next(input logic [IDX_W-1:0] idx,
                                                 input logic [LVL_W-1:0] count);
    if ({1'b0, idx} == count - LVL_W'(1)) return '0;
    return idx + IDX_W'(1);
  endfunction
endpackage

// File: rtl/rxq_cfg_decode.sv
module rxq_cfg_decode
  import rxq_pkg::*;
(
  input  logic [CODE_W-1:0] size_code,
  input  logic [CODE_W-1:0] wm_code,
  output logic [LVL_W-1:0]  size_eff,
  output logic              exists,
  output logic              wm_en,
  output logic [LVL_W-1:0]  wm_lvl
);
  always_comb begin
    size_eff = clamp_size(size_code);
    exists   = (size_eff != '0);
    wm_en    = wmark_on(wm_code);
    wm_lvl   = LVL_W'(wm_code);
  end
endmodule

// File: rtl/rxq_ptr_core.sv
module rxq_ptr_core
  import rxq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] size_eff,
  input  logic             exists,
  input  logic             ovw_mode,
  input  logic             wr_stb,
  input  logic             rd_ack,
  output logic [IDX_W-1:0] put_q,
  output logic [IDX_W-1:0] get_q,
  output logic [LVL_W-1:0] lvl_q,
  output logic [LVL_W-1:0] lvl_d,
  output logic             full_now,
  output logic             take_evt,
  output logic             store_evt,
  output logic             ovw_evt,
  output logic             lost_evt
);
  logic [IDX_W-1:0] put_d, get_d;

  always_comb begin
    full_now  = exists && (lvl_q == size_eff);
    take_evt  = exists && rd_ack && (lvl_q != '0);
    store_evt = exists && wr_stb && (!full_now || take_evt);
    ovw_evt   = exists && wr_stb && full_now && !take_evt && ovw_mode;
    lost_evt  = exists && wr_stb && full_now && !take_evt && !ovw_mode;

    put_d = put_q;
    get_d = get_q;
    lvl_d = lvl_q;
    if (store_evt || ovw_evt) put_d = ring_next(put_q, size_eff);
    if (take_evt  || ovw_evt) get_d = ring_next(get_q, size_eff);
    if (store_evt && !take_evt)      lvl_d = lvl_q + LVL_W'(1);
    else if (take_evt && !store_evt) lvl_d = lvl_q - LVL_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      put_q <= '0;
      get_q <= '0;
      lvl_q <= '0;
    end else begin
      put_q <= put_d;
      get_q <= get_d;
      lvl_q <= lvl_d;
    end
  end
endmodule

// File: rtl/rxq_irq_flags.sv
module rxq_irq_flags
  import rxq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exists,
  input  logic [LVL_W-1:0] size_eff,
  input  logic             wm_en,
  input  logic [LVL_W-1:0] wm_lvl,
  input  logic [LVL_W-1:0] lvl_q,
  input  logic [LVL_W-1:0] lvl_d,
  input  logic             lost_evt,
  input  logic             clr,
  output logic             wm_evt,
  output logic             full_evt,
  output logic             irq_wm,
  output logic             irq_full,
  output logic             irq_lost
);
  always_comb begin
    wm_evt   = wm_en && (lvl_d != lvl_q) && (lvl_d == wm_lvl);
    full_evt = exists && (lvl_d != lvl_q) && (lvl_d == size_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_wm   <= 1'b0;
      irq_full <= 1'b0;
      irq_lost <= 1'b0;
    end else begin
      irq_wm   <= wm_evt   | (irq_wm   & ~clr);
      irq_full <= full_evt | (irq_full & ~clr);
      irq_lost <= lost_evt | (irq_lost & ~clr);
    end
  end
endmodule

// File: rtl/rxq_index_mgr.sv
module rxq_index_mgr
  import rxq_pkg::*;
#(
  parameter int ELEM_WORDS = 4,
  parameter int START_W    = 14,
  parameter int ADDR_W     = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CODE_W-1:0]   cfg_size,
  input  logic [CODE_W-1:0]   cfg_wmark,
  input  logic                cfg_ovw,
  input  logic [START_W-1:0]  cfg_start,
  input  logic                wr_stb,
  input  logic                rd_ack,
  input  logic                irq_clr,
  output logic [ADDR_W-1:0]   wr_addr,
  output logic [IDX_W-1:0]    put_idx,
  output logic [IDX_W-1:0]    get_idx,
  output logic [LVL_W-1:0]    fill_lvl,
  output logic                full,
  output logic                irq_wm,
  output logic                irq_full,
  output logic                irq_lost
);
  localparam int MUL_W = ADDR_W + 8;

  logic [LVL_W-1:0] size_eff, wm_lvl, lvl_d;
  logic             exists, wm_en;
  logic             take_evt, store_evt, ovw_evt, lost_evt, wm_evt, full_evt;

  function automatic logic [ADDR_W-1:0] slot_addr(input logic [START_W-1:0] base,
                                                  input logic [IDX_W-1:0]   idx);
    logic [MUL_W-1:0] off;
    off = MUL_W'(idx) * MUL_W'(ELEM_WORDS);
    return ADDR_W'(MUL_W'(base) + off);
  endfunction

  rxq_cfg_decode u_dec (
    .size_code (cfg_size),
    .wm_code   (cfg_wmark),
    .size_eff  (size_eff),
    .exists    (exists),
    .wm_en     (wm_en),
    .wm_lvl    (wm_lvl)
  );

  rxq_ptr_core u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .size_eff  (size_eff),
    .exists    (exists),
    .ovw_mode  (cfg_ovw),
    .wr_stb    (wr_stb),
    .rd_ack    (rd_ack),
    .put_q     (put_idx),
    .get_q     (get_idx),
    .lvl_q     (fill_lvl),
    .lvl_d     (lvl_d),
    .full_now  (full),
    .take_evt  (take_evt),
    .store_evt (store_evt),
    .ovw_evt   (ovw_evt),
    .lost_evt  (lost_evt)
  );

  rxq_irq_flags u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .exists   (exists),
    .size_eff (size_eff),
    .wm_en    (wm_en),
    .wm_lvl   (wm_lvl),
    .lvl_q    (fill_lvl),
    .lvl_d    (lvl_d),
    .lost_evt (lost_evt),
    .clr      (irq_clr),
    .wm_evt   (wm_evt),
    .full_evt (full_evt),
    .irq_wm   (irq_wm),
    .irq_full (irq_full),
    .irq_lost (irq_lost)
  );

  assign wr_addr = slot_addr(cfg_start, put_idx);
endmodule

// File: rtl/rxq_index_chk.sv
module rxq_index_chk
  import rxq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] cfg_size,
  input logic              cfg_ovw,
  input logic              wr_stb,
  input logic              rd_ack,
  input logic              irq_clr,
  input logic [IDX_W-1:0]  put_idx,
  input logic [IDX_W-1:0]  get_idx,
  input logic [LVL_W-1:0]  fill_lvl,
  input logic              full,
  input logic              irq_full,
  input logic              irq_lost,
  input logic [LVL_W-1:0]  size_eff,
  input logic              lost_evt
);
  p_nosize_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_size == '0) |=> ($stable(fill_lvl) && $stable(put_idx) && $stable(get_idx)))
    else $error("R1 state moved with no queue");

  p_idx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (size_eff != '0) |-> (({1'b0, put_idx} < size_eff) && ({1'b0, get_idx} < size_eff)))
    else $error("R3 index out of range");

  p_lost_blocking_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && full && !cfg_ovw && !rd_ack) |=> (irq_lost && $stable(fill_lvl) && $stable(put_idx)))
    else $error("R5 blocked write not reported");

  p_ovw_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && full && cfg_ovw && !rd_ack) |=> ($stable(fill_lvl) && !$rose(irq_lost)))
    else $error("R6 overwrite changed level");

  p_full_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (fill_lvl == ((cfg_size > 7'd64) ? 7'd64 : cfg_size)))
    else $error("R7 full flag disagrees with level");

  p_pair_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && rd_ack && fill_lvl != '0 && size_eff != '0) |=> $stable(fill_lvl))
    else $error("R9 paired access changed level");

  p_empty_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && !wr_stb && fill_lvl == '0) |=> ($stable(get_idx) && fill_lvl == '0))
    else $error("R9 empty ack had effect");

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_full && !irq_clr) |=> irq_full)
    else $error("R10 full flag dropped without clear");

  p_lost_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_lost) |-> $past(lost_evt))
    else $error("R5 lost flag without drop");
endmodule

bind rxq_index_mgr rxq_index_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_size (cfg_size),
  .cfg_ovw  (cfg_ovw),
  .wr_stb   (wr_stb),
  .rd_ack   (rd_ack),
  .irq_clr  (irq_clr),
  .put_idx  (put_idx),
  .get_idx  (get_idx),
  .fill_lvl (fill_lvl),
  .full     (full),
  .irq_full (irq_full),
  .irq_lost (irq_lost),
  .size_eff (size_eff),
  .lost_evt (lost_evt)
);

// File: tb/rxq_index_mgr_bench.sv
module rxq_index_mgr_bench;
  localparam int EW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  cfg_size = '0, cfg_wmark = '0;
  logic        cfg_ovw = 1'b0;
  logic [13:0] cfg_start = '0;
  logic        wr_stb = 1'b0, rd_ack = 1'b0, irq_clr = 1'b0;
  logic [15:0] wr_addr;
  logic [5:0]  put_idx, get_idx;
  logic [6:0]  fill_lvl;
  logic        full, irq_wm, irq_full, irq_lost;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  int m_put, m_get, m_lvl;
  bit m_wm, m_full, m_lost;

  always #2 clk = ~clk;

  rxq_index_mgr u_rxq_index_mgr (
    .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_wmark(cfg_wmark),
    .cfg_ovw(cfg_ovw), .cfg_start(cfg_start), .wr_stb(wr_stb), .rd_ack(rd_ack),
    .irq_clr(irq_clr), .wr_addr(wr_addr), .put_idx(put_idx), .get_idx(get_idx),
    .fill_lvl(fill_lvl), .full(full), .irq_wm(irq_wm), .irq_full(irq_full),
    .irq_lost(irq_lost)
  );

  function automatic int depth_of(input int code);
    return (code > 64) ? 64 : code;
  endfunction

  function automatic int addr_of(input int base, input int idx);
    return (base + idx * EW) % 65536;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One cycle of the reference, applied with the same stimulus as the design.
  task automatic model_step(input bit w, input bit r, input bit c);
    int  n, old, wmv;
    bit  take, is_full, lost_e;
    n = depth_of(int'(cfg_size));
    old = m_lvl;
    lost_e = 0;
    if (n != 0) begin
      is_full = (m_lvl == n);
      take = r && (m_lvl > 0);
      if (w && (!is_full || take)) begin
        m_put = (m_put + 1) % n;
        if (!take) m_lvl++;
      end else if (w && cfg_ovw) begin
        m_put = (m_put + 1) % n;
        m_get = (m_get + 1) % n;
      end else if (w) begin
        lost_e = 1;
      end
      if (take) begin
        m_get = (m_get + 1) % n;
        if (!w) m_lvl--;
      end
    end
    wmv = int'(cfg_wmark);
    m_wm   = ((wmv >= 1) && (wmv <= 64) && (m_lvl != old) && (m_lvl == wmv)) || (m_wm && !c);
    m_full = ((n != 0) && (m_lvl != old) && (m_lvl == n)) || (m_full && !c);
    m_lost = lost_e || (m_lost && !c);
  endtask

  task automatic compare_all(input string tag);
    int n;
    n = depth_of(int'(cfg_size));
    chk(tag == "" ? "R3" : tag, "put_idx", int'(put_idx), m_put);
    chk(tag == "" ? "R3" : tag, "get_idx", int'(get_idx), m_get);
    chk(tag == "" ? "R7" : tag, "fill_lvl", int'(fill_lvl), m_lvl);
    chk("R7", "full", int'(full), int'((n != 0) && (m_lvl == n)));
    chk("R4", "irq_wm", int'(irq_wm), int'(m_wm));
    chk("R10", "irq_full", int'(irq_full), int'(m_full));
    chk("R5", "irq_lost", int'(irq_lost), int'(m_lost));
    chk("R8", "wr_addr", int'(wr_addr), addr_of(int'(cfg_start), m_put));
  endtask

  task automatic cycle(input bit w, input bit r, input bit c, input string tag);
    @(negedge clk);
    wr_stb = w; rd_ack = r; irq_clr = c;
    model_step(w, r, c);
    @(posedge clk);
    #1;
    compare_all(tag);
  endtask

  task automatic restart(input int sz, input int wm, input bit ovw, input int base);
    @(negedge clk);
    rst_n = 1'b0;
    wr_stb = 0; rd_ack = 0; irq_clr = 0;
    cfg_size = 7'(sz); cfg_wmark = 7'(wm); cfg_ovw = ovw; cfg_start = 14'(base);
    m_put = 0; m_get = 0; m_lvl = 0; m_wm = 0; m_full = 0; m_lost = 0;
    @(negedge clk);
    chk("R11", "reset level", int'(fill_lvl), 0);
    chk("R11", "reset put", int'(put_idx), 0);
    chk("R11", "reset flags", int'({irq_wm, irq_full, irq_lost}), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd20240607));

    // R1: no queue
    restart(0, 1, 0, 100);
    for (int i = 0; i < 6; i++) cycle(1, i[0], 0, "R1");

    // R2 + R7: code 100 acts as 64, fill to full
    restart(100, 64, 0, 16);
    for (int i = 0; i < 64; i++) cycle(1, 0, 0, "R2");
    chk("R2", "clamped full", int'(full), 1);
    chk("R7", "irq_full set", int'(irq_full), 1);
    chk("R4", "wm at 64", int'(irq_wm), 1);
    // R5: blocking drop
    cycle(1, 0, 0, "R5");
    chk("R5", "lost raised", int'(irq_lost), 1);
    // R9: full plus ack accepted
    cycle(1, 1, 0, "R9");
    // R10: clear
    cycle(0, 0, 1, "R10");
    chk("R10", "flags cleared", int'({irq_wm, irq_full, irq_lost}), 0);

    // R3 wrap with depth 5, R9 empty ack
    restart(5, 3, 0, 40);
    cycle(0, 1, 0, "R9");
    for (int i = 0; i < 12; i++) cycle(1, 1, 0, "R3");
    for (int i = 0; i < 4; i++) cycle(1, 0, 0, "R4");
    for (int i = 0; i < 4; i++) cycle(0, 1, 0, "R3");

    // R6 overwrite with depth 3
    restart(3, 70, 1, 8);
    for (int i = 0; i < 7; i++) cycle(1, 0, 0, "R6");
    chk("R6", "no lost in overwrite", int'(irq_lost), 0);
    chk("R4", "wm code 70 off", int'(irq_wm), 0);

    // depth 1
    restart(1, 1, 0, 3);
    for (int i = 0; i < 6; i++) cycle(1, i[1], 0, "R3");

    // random configurations
    for (int k = 0; k < 14; k++) begin
      int sz, wm;
      sz = int'($urandom_range(0, 80));
      if (k == 0) sz = 64;
      if (k == 1) sz = 127;
      wm = int'($urandom_range(0, 70));
      if (wm > 0 && wm <= 64 && sz > 0 && wm > depth_of(sz)) wm = depth_of(sz);
      restart(sz, wm, 1'($urandom_range(0, 1)), int'($urandom_range(0, 16383)));
      for (int i = 0; i < 300; i++) begin
        bit w, r, c;
        w = ($urandom_range(0, 99) < 60);
        r = ($urandom_range(0, 99) < 40);
        c = ($urandom_range(0, 99) < 5);
        cycle(w, r, c, "");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    done = 1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule